// File: doc/BRIEF.md
# Blinded Constant-Time Modular Exponentiation Engine

This block raises a base to a power modulo an odd modulus, as used in RSA-style public-key work. The caller supplies the base, the secret exponent, a blinding term, the modulus and the constant R² mod N, where R = 2^WIDTH. A one-cycle start pulse loads all of them. The block first adds the blinding term to the exponent. It then walks the blinded exponent from its least significant bit upward, across its full width.

Each exponent bit costs exactly two Montgomery products. The first multiplies the accumulator by the running base. Its result lands in the real accumulator when the bit is one and in a discard slot when the bit is zero. The second squares the running base. The control sequence never looks at key bits, so the operation count and the cycle count are fixed.

Before the scan, the base and the accumulator are brought into the Montgomery domain. After the scan, a product with 1 brings the answer back out. A single radix-2 bit-serial Montgomery multiplier, with a conditional final subtraction, does all of this work. A one-cycle done pulse marks the result.

Top module: `modexp_engine`

## Requirements
- R1: When done is asserted, result equals baseIn^E mod modIn. Here E = (expIn + blindIn) mod 2^EXP_WIDTH, modIn is odd and greater than 1, and r2In = 2^(2·WIDTH) mod modIn.
- R2: done rises exactly (2·EXP_WIDTH+3)·(WIDTH+3) clock edges after the edge that captured start. This count does not depend on the base, the exponent, the blinding term or the modulus.
- R3: The exponent applied is the sum expIn + blindIn, truncated to EXP_WIDTH bits. Adding any multiple of the group order leaves the result unchanged, and a carry out of the top bit is dropped.
- R4: A base that is not below the modulus is accepted and reduced. The result is the same as for baseIn mod modIn.
- R5: done is high for exactly one cycle per operation.
- R6: When done is high, result is strictly below the modulus captured at start.
- R7: result changes only in the cycle in which done is high. It holds its value while idle and throughout the next operation, until that operation's done.
- R8: A start pulse while an operation is running has no effect. The running operation keeps its operands and its completion time.
- R9: While reset is held, done is 0 and result is 0.
- R10: An exponent that sums to zero gives result 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin; ignored while busy |
| baseIn | input | WIDTH | Base, any WIDTH-bit value |
| expIn | input | EXP_WIDTH | Secret exponent |
| blindIn | input | EXP_WIDTH | Precomputed blinding term, a multiple of the group order |
| modIn | input | WIDTH | Odd modulus |
| r2In | input | WIDTH | 2^(2·WIDTH) mod modIn |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Modular power, held until the next completion |

## Verification
The bench builds the engine with WIDTH = 16 and EXP_WIDTH = 24. With these values every expected power can be reasoned out by hand or with 64-bit integers. A full operation takes under a thousand cycles, so the top exponent bit, the dropped carry of the blinding sum, Fermat-style blinding with a prime modulus, and moduli close to 2^16 can all be tried in a short run. The same narrow build also makes it cheap to watch the exact completion edge for every vector. It also makes it cheap to start a second operation in the middle of a run.

// File: rtl/modexp_pkg.sv
`timescale 1ns/1ps
package modexp_pkg;

  // Which Montgomery product is in flight; also selects operands and writeback.
  typedef enum logic [2:0] {
    MUL_NONE,
    MUL_BASE_IN,   // baseRaw * R^2  -> base in Montgomery form
    MUL_ACC_INIT,  // 1 * R^2        -> Montgomery one
    MUL_ACC_STEP,  // acc * base     -> acc bank slot chosen by exponent bit
    MUL_SQUARE,    // base * base    -> base
    MUL_OUT        // acc * 1        -> plain result
  } mulOp_e;

  typedef struct packed {
    logic   loadOps;  // capture operands at accepted start
    logic   mulGo;    // launch a product this cycle
    mulOp_e op;       // product kind, held until its completion
    logic   stepExp;  // advance to next exponent bit
  } dpCtl_t;

endpackage

// File: rtl/mont_mul.sv
`timescale 1ns/1ps
// Radix-2 bit-serial Montgomery product: prod = a*b*2^-WIDTH mod n.
// Needs n odd and b < n; a may be any WIDTH-bit value.
module mont_mul #(
  parameter int WIDTH = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] modN,
  output logic             done,
  output logic [WIDTH-1:0] prod
);
  localparam int SW = WIDTH + 2;
  localparam int CW = $clog2(WIDTH + 1);

  logic [SW-1:0]    accQ;
  logic [WIDTH-1:0] aShQ;
  logic [WIDTH-1:0] bQ;
  logic [CW-1:0]    cntQ;
  logic             runQ;
  logic             finQ;

  logic [SW-1:0] addB;
  logic [SW-1:0] sumPart;
  logic [SW-1:0] sumOdd;
  logic [SW-1:0] accNext;
  logic          needSub;

  always_comb begin
    addB    = aShQ[0] ? {2'b00, bQ} : '0;
    sumPart = accQ + addB;
    sumOdd  = sumPart[0] ? (sumPart + {2'b00, modN}) : sumPart;
    accNext = sumOdd >> 1;
    needSub = (accQ >= {2'b00, modN});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      aShQ <= '0;
      bQ   <= '0;
      cntQ <= '0;
      runQ <= 1'b0;
      finQ <= 1'b0;
      done <= 1'b0;
      prod <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        accQ <= '0;
        aShQ <= opA;
        bQ   <= opB;
        cntQ <= '0;
        runQ <= 1'b1;
        finQ <= 1'b0;
      end else if (runQ) begin
        accQ <= accNext;
        aShQ <= aShQ >> 1;
        cntQ <= cntQ + 1'b1;
        if (cntQ == CW'(WIDTH - 1)) begin
          runQ <= 1'b0;
          finQ <= 1'b1;
        end
      end else if (finQ) begin
        finQ <= 1'b0;
        done <= 1'b1;
        prod <= needSub ? (accQ[WIDTH-1:0] - modN) : accQ[WIDTH-1:0];
      end
    end
  end
endmodule

// File: rtl/modexp_dp.sv
`timescale 1ns/1ps
module modexp_dp
  import modexp_pkg::*;
#(
  parameter int WIDTH     = 1024,
  parameter int EXP_WIDTH = 1088
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [WIDTH-1:0]     baseIn,
  input  logic [EXP_WIDTH-1:0] expIn,
  input  logic [EXP_WIDTH-1:0] blindIn,
  input  logic [WIDTH-1:0]     modIn,
  input  logic [WIDTH-1:0]     r2In,
  output logic                 mulDone,
  output logic [WIDTH-1:0]     result
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0]     modQ;
  logic [WIDTH-1:0]     r2Q;
  logic [WIDTH-1:0]     baseRawQ;
  logic [WIDTH-1:0]     baseMQ;
  logic [WIDTH-1:0]     accBank [2];  // [1] real accumulator, [0] discard slot
  logic [EXP_WIDTH-1:0] expShQ;

  logic [WIDTH-1:0] mulA;
  logic [WIDTH-1:0] mulB;
  logic [WIDTH-1:0] mulP;

  always_comb begin
    unique case (ctl.op)
      MUL_BASE_IN:  begin mulA = baseRawQ;   mulB = r2Q;    end
      MUL_ACC_INIT: begin mulA = ONE;        mulB = r2Q;    end
      MUL_ACC_STEP: begin mulA = accBank[1]; mulB = baseMQ; end
      MUL_SQUARE:   begin mulA = baseMQ;     mulB = baseMQ; end
      MUL_OUT:      begin mulA = accBank[1]; mulB = ONE;    end
      default:      begin mulA = '0;         mulB = '0;     end
    endcase
  end

  mont_mul #(.WIDTH(WIDTH)) mul_i (
    .clk  (clk),
    .rstN (rstN),
    .go   (ctl.mulGo),
    .opA  (mulA),
    .opB  (mulB),
    .modN (modQ),
    .done (mulDone),
    .prod (mulP)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modQ     <= '0;
      r2Q      <= '0;
      baseRawQ <= '0;
      baseMQ   <= '0;
      expShQ   <= '0;
      result   <= '0;
      for (int i = 0; i < 2; i++) accBank[i] <= '0;
    end else begin
      if (ctl.loadOps) begin
        modQ     <= modIn;
        r2Q      <= r2In;
        baseRawQ <= baseIn;
        expShQ   <= expIn + blindIn;
      end
      if (ctl.stepExp) expShQ <= expShQ >> 1;
      if (mulDone) begin
        unique case (ctl.op)
          MUL_BASE_IN:  baseMQ <= mulP;
          MUL_ACC_INIT: accBank[1] <= mulP;
          MUL_ACC_STEP: accBank[expShQ[0]] <= mulP;  // same path for 0 and 1
          MUL_SQUARE:   baseMQ <= mulP;
          MUL_OUT:      result <= mulP;
          default:      ;
        endcase
      end
    end
  end
endmodule

// File: rtl/modexp_ctrl.sv
`timescale 1ns/1ps
module modexp_ctrl
  import modexp_pkg::*;
#(
  parameter int EXP_WIDTH = 1088
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   mulDone,
  output dpCtl_t ctl,
  output logic   done
);
  localparam int BW = $clog2(EXP_WIDTH + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_BASE, ST_INIT, ST_ACC, ST_SQR, ST_OUT
  } state_e;

  state_e        stateQ;
  logic          waitQ;
  logic [BW-1:0] bitCntQ;

  always_comb begin
    ctl = '0;
    unique case (stateQ)
      ST_BASE: ctl.op = MUL_BASE_IN;
      ST_INIT: ctl.op = MUL_ACC_INIT;
      ST_ACC:  ctl.op = MUL_ACC_STEP;
      ST_SQR:  ctl.op = MUL_SQUARE;
      ST_OUT:  ctl.op = MUL_OUT;
      default: ctl.op = MUL_NONE;
    endcase
    ctl.loadOps = (stateQ == ST_IDLE) && start;
    ctl.mulGo   = (stateQ != ST_IDLE) && !waitQ;
    ctl.stepExp = (stateQ == ST_SQR) && waitQ && mulDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      waitQ   <= 1'b0;
      bitCntQ <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stateQ == ST_IDLE) begin
        if (start) begin
          stateQ  <= ST_BASE;
          waitQ   <= 1'b0;
          bitCntQ <= '0;
        end
      end else if (!waitQ) begin
        waitQ <= 1'b1;
      end else if (mulDone) begin
        waitQ <= 1'b0;
        unique case (stateQ)
          ST_BASE: stateQ <= ST_INIT;
          ST_INIT: stateQ <= ST_ACC;
          ST_ACC:  stateQ <= ST_SQR;
          ST_SQR: begin
            bitCntQ <= bitCntQ + 1'b1;
            stateQ  <= (bitCntQ == BW'(EXP_WIDTH - 1)) ? ST_OUT : ST_ACC;
          end
          ST_OUT: begin
            stateQ <= ST_IDLE;
            done   <= 1'b1;
          end
          default: stateQ <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/modexp_engine.sv
`timescale 1ns/1ps
module modexp_engine
  import modexp_pkg::*;
#(
  parameter int WIDTH     = 1024,
  parameter int EXP_WIDTH = 1088
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [WIDTH-1:0]     baseIn,
  input  logic [EXP_WIDTH-1:0] expIn,
  input  logic [EXP_WIDTH-1:0] blindIn,
  input  logic [WIDTH-1:0]     modIn,
  input  logic [WIDTH-1:0]     r2In,
  output logic                 done,
  output logic [WIDTH-1:0]     result
);
  dpCtl_t ctl;
  logic   mulDone;

  modexp_ctrl #(.EXP_WIDTH(EXP_WIDTH)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mulDone (mulDone),
    .ctl     (ctl),
    .done    (done)
  );

  modexp_dp #(.WIDTH(WIDTH), .EXP_WIDTH(EXP_WIDTH)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .baseIn  (baseIn),
    .expIn   (expIn),
    .blindIn (blindIn),
    .modIn   (modIn),
    .r2In    (r2In),
    .mulDone (mulDone),
    .result  (result)
  );
endmodule

// File: rtl/modexp_engine_chk.sv
`timescale 1ns/1ps
module modexp_engine_chk #(
  parameter int WIDTH     = 1024,
  parameter int EXP_WIDTH = 1088
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] modIn,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  localparam int unsigned LAT = (2 * EXP_WIDTH + 3) * (WIDTH + 3);

  logic             busyQ;
  int unsigned      cntQ;
  logic [WIDTH-1:0] modHeldQ;
  logic             accept;

  assign accept = start && (!busyQ || done);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      cntQ     <= 0;
      modHeldQ <= '0;
    end else if (accept) begin
      busyQ    <= 1'b1;
      cntQ     <= 0;
      modHeldQ <= modIn;
    end else if (done) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      cntQ <= cntQ + 1;
    end
  end

  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyQ && cntQ == LAT));

  a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cntQ <= LAT));

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_result_below_mod: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result < modHeldQ));

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      a_r9_reset_quiet: assert (!done && result == '0);
    end
  end
endmodule

bind modexp_engine modexp_engine_chk #(.WIDTH(WIDTH), .EXP_WIDTH(EXP_WIDTH)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .modIn  (modIn),
  .done   (done),
  .result (result)
);

// File: tb/modexp_engine_tb_top.sv
`timescale 1ns/1ps
module modexp_engine_tb_top;
  localparam int W   = 16;
  localparam int EW  = 24;
  localparam int LAT = (2 * EW + 3) * (W + 3);
  localparam int NV  = 10;

  // {base[16], exp[24], blind[24], mod[16], expect[16], tag[8]}
  localparam logic [103:0] VECS [NV] = '{
    {16'd3,     24'd5,        24'd0,       16'd7,     16'd5,     8'd1},
    {16'd2,     24'd10,       24'd0,       16'd1001,  16'd23,    8'd1},
    {16'd10,    24'd5,        24'd0,       16'd7,     16'd5,     8'd4},
    {16'd1234,  24'd0,        24'd0,       16'd65521, 16'd1,     8'd10},
    {16'd0,     24'd3,        24'd0,       16'd13,    16'd0,     8'd1},
    {16'd2,     24'd3,        24'd50,      16'd11,    16'd8,     8'd3},
    {16'd2,     24'hFFFFFF,   24'd4,       16'd11,    16'd8,     8'd3},
    {16'd65534, 24'd7,        24'd0,       16'd65535, 16'd65534, 8'd1},
    {16'd3,     24'd2,        24'd6552000, 16'd65521, 16'd9,     8'd3},
    {16'd5,     24'h800000,   24'd0,       16'd7,     16'd4,     8'd1}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  baseIn = '0;
  logic [EW-1:0] expIn = '0;
  logic [EW-1:0] blindIn = '0;
  logic [W-1:0]  modIn = '0;
  logic [W-1:0]  r2In = '0;
  logic          done;
  logic [W-1:0]  result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  modexp_engine #(.WIDTH(W), .EXP_WIDTH(EW)) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .baseIn  (baseIn),
    .expIn   (expIn),
    .blindIn (blindIn),
    .modIn   (modIn),
    .r2In    (r2In),
    .done    (done),
    .result  (result)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] calcR2(input logic [W-1:0] n);
    longint unsigned v = 1 % longint'(n);
    for (int i = 0; i < 2 * W; i++) v = (v * 2) % longint'(n);
    return W'(v);
  endfunction

  function automatic string tagName(input logic [7:0] t);
    case (t)
      8'd3:    return "R3";
      8'd4:    return "R4";
      8'd10:   return "R10";
      default: return "R1";
    endcase
  endfunction

  // Starts one operation; optionally pulses start again midAt cycles in.
  task automatic runOp(input logic [W-1:0] b, input logic [EW-1:0] e,
                       input logic [EW-1:0] bl, input logic [W-1:0] n,
                       input int midAt,
                       output logic [W-1:0] got, output int lat,
                       output bit holdOk, output bit pulseOk);
    logic [W-1:0] prior;
    prior = result;
    @(negedge clk);
    baseIn = b; expIn = e; blindIn = bl; modIn = n; r2In = calcR2(n);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    holdOk = 1'b1;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (midAt != 0 && lat == midAt) begin
        baseIn = '1; expIn = 24'd3; blindIn = '0; modIn = 16'd13;
        r2In = calcR2(16'd13);
        start = 1'b1;
      end else if (midAt != 0 && lat == midAt + 1) begin
        start = 1'b0;
      end
      if (!done && result !== prior) holdOk = 1'b0;
    end while (!done && lat < LAT + 50);
    got = result;
    @(posedge clk);
    @(negedge clk);
    pulseOk = !done;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got;
    logic [W-1:0] keep;
    int lat;
    bit holdOk;
    bit pulseOk;

    // R9: outputs quiet under reset
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R9", "done in reset", longint'(done), 0);
    check(result == '0, "R9", "result in reset", longint'(result), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [103:0] v;
      v = VECS[i];
      runOp(v[103:88], v[87:64], v[63:40], v[39:24], 0, got, lat, holdOk, pulseOk);
      check(got == v[23:8], tagName(v[7:0]), $sformatf("vector %0d result", i),
            longint'(got), longint'(v[23:8]));
      check(lat == LAT, "R2", $sformatf("vector %0d latency", i), lat, LAT);
      check(pulseOk, "R5", $sformatf("vector %0d done width", i), 0, 1);
      check(got < v[39:24], "R6", $sformatf("vector %0d below modulus", i),
            longint'(got), longint'(v[39:24]));
      check(holdOk, "R7", $sformatf("vector %0d hold during run", i), 0, 1);
    end

    // R7: result holds while idle
    keep = result;
    repeat (40) @(negedge clk);
    check(result == keep, "R7", "idle hold", longint'(result), longint'(keep));

    // R8: start mid-run is ignored (operands and timing unchanged)
    runOp(16'd3, 24'd5, 24'd0, 16'd7, 100, got, lat, holdOk, pulseOk);
    check(got == 16'd5, "R8", "result after mid-run start", longint'(got), 5);
    check(lat == LAT, "R8", "latency after mid-run start", lat, LAT);
    check(holdOk, "R7", "hold across interrupted run", 0, 1);

    // R8: nothing pending after the ignored start
    repeat (LAT + 20) @(negedge clk) begin
      if (done) holdOk = 1'b0;
    end
    check(holdOk, "R8", "no second completion", 1, 0);
    check(result == 16'd5, "R8", "result unchanged afterwards", longint'(result), 5);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule